// File: doc/BRIEF.md
# Pixel Bit-Depth Reducer with Pseudo-Random Dither

This block narrows the depth of each colour channel in a display pixel stream. It takes 12-bit channels and keeps 6, 8 or 10 significant bits of each. The low bits are cleared and the channel width stays the same, so the next stage can pack the result however it needs to. There are two ways to narrow a channel. The first is truncation, which either cuts the low bits or rounds them at half an LSB. The second is spatial dither: a 28-bit LFSR sample is added below the kept LSB, the sum saturates at full scale, and only then are the low bits cut.

The pixels flow through a valid/ready interface and a two-stage pipeline. The pipeline moves only when its output register is empty or is being consumed. `in_rdy` is high exactly when `out_vld` is low or `out_rdy` is high. A pixel transfers on a rising edge where `in_vld` and `in_rdy` are both high. While `out_vld` is high and `out_rdy` is low, the output pixel stays frozen. The configuration pins are plain levels, and each pixel uses the values they hold on the edge where that pixel transfers.

The noise source is a bank of three LFSRs. They can share one polynomial for all channels or run a separate polynomial per channel. The seeds can be reloaded once when dither is switched on, or reloaded at every frame with a per-frame perturbation taken from a small counter.

Top module: `pix_depth_reducer`

## Requirements
- R1: A pixel transfers when `in_vld` and `in_rdy` are both high, and `in_rdy` equals `!out_vld || out_rdy`. While `out_vld` is high and `out_rdy` is low, the output channels and `out_vld` hold their values.
- R2: Without stalls, a pixel accepted on edge n drives `out_vld` high after edge n+1. Pixels leave in the order they arrive, and `out_vld` is high only for pixels that were accepted.
- R3: When dither is inactive and `in_enc` is not 1, truncation applies only if `cfg_trunc_en` is 1. Depth code 0 keeps 6 bits and code 1 keeps 8 bits; codes 2 and 3 pass the pixel through unchanged. Kept bits are the top bits, and the cleared bits read as zero.
- R4: When `cfg_trunc_round` is 1 and truncation is in effect on a non-4:2:2 pixel, half an LSB of the kept width is added before the cut. The sum saturates at 4095.
- R5: When `in_enc` is 1 (YCbCr 4:2:2) and dither is inactive, `cfg_trunc_en` is ignored. Depth code 1 keeps 8 bits, code 2 keeps 10 bits, and any other code passes the pixel through. Rounding is never applied to these pixels.
- R6: Dither is active when `cfg_dith_en` is 1 and `cfg_dith_depth` is 0, 1 or 2, which keep 6, 8 or 10 bits. While dither is active, truncation settings have no effect. The F = 12 − kept low bits of the channel's noise are added, the sum saturates at 4095, and the F low bits are cleared. Depth code 3 leaves dither inactive.
- R7: Each LFSR is a 28-bit left-shifting register whose new bit 0 is `s[27] ^ s[t-1]`, for the polynomial x^28+x^t+1. It steps once per accepted pixel while dither is active, and the pixel uses the state as it was before that step.
- R8: With `cfg_rgb_rand` at 0, all three channels take their noise from the LFSR with t=3 seeded by `cfg_seed_r`. With it at 1, R uses t=3 and `cfg_seed_r`, G uses t=9 and `cfg_seed_g`, and B uses t=13 and `cfg_seed_b`.
- R9: Any cycle with dither inactive disarms the reload. The first accepted pixel with dither active while disarmed uses the seed itself as its LFSR state.
- R10: With `cfg_frame_rand` at 1, an accepted `in_sof` pixel with dither active uses `seed ^ (cnt << S)` as its state. S is 16 for dither depths 0 and 1 and 8 for depth 2. The 4-bit counter `cnt` then advances, and it returns to 0 after reaching 15 (depths 0 and 1) or 3 (depth 2). The counter is held at 0 while `cfg_frame_rand` is 0.
- R11: With `cfg_highpass` at 1, the noise is the difference, modulo 2^28, between the LFSR state used now and the state that LFSR used for the previous dithered pixel. That previous state is 0 after reset.
- R12: After reset, `out_vld` is 0 and all output channels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input pixel valid |
| in_rdy | output | 1 | Block can accept a pixel |
| in_sof | input | 1 | Pixel is first of a frame |
| in_enc | input | 2 | Encoding: 1 = YCbCr 4:2:2, other values = 4:4:4 behaviour |
| in_r | input | 12 | Channel R / Cr |
| in_g | input | 12 | Channel G / Y |
| in_b | input | 12 | Channel B / Cb |
| out_vld | output | 1 | Output pixel valid |
| out_rdy | input | 1 | Downstream accepts output |
| out_r | output | 12 | Reduced channel R / Cr |
| out_g | output | 12 | Reduced channel G / Y |
| out_b | output | 12 | Reduced channel B / Cb |
| cfg_trunc_en | input | 1 | Truncation enable (non-4:2:2) |
| cfg_trunc_depth | input | 2 | Truncation depth code |
| cfg_trunc_round | input | 1 | Round instead of cut |
| cfg_dith_en | input | 1 | Spatial dither enable |
| cfg_dith_depth | input | 2 | Dither depth code |
| cfg_rgb_rand | input | 1 | Separate polynomial per channel |
| cfg_frame_rand | input | 1 | Reseed at every frame start |
| cfg_highpass | input | 1 | Difference-of-samples noise |
| cfg_seed_r | input | 28 | Seed for the R LFSR |
| cfg_seed_g | input | 28 | Seed for the G LFSR |
| cfg_seed_b | input | 28 | Seed for the B LFSR |

## Verification
Fixed values such as 0xABC and 0xFFF separate a plain cut from rounding, and they show the saturation at full scale that only rounding and dither can reach. Random channel values with dither enabled are run four ways: shared and per-channel polynomials, with and without high-pass noise, and with reloads done once or at every frame. These runs separate the three taps, the seed-to-channel mapping and the counter perturbation. Frame runs long enough to wrap the counter at both depths separate the wrap points of 15 and 3. A random `out_rdy` pattern together with back-to-back pixels shows that stalls neither drop, repeat nor reorder pixels, and that the LFSRs advance only on accepted pixels.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

  typedef enum logic [1:0] {
    ENC_444 = 2'd0,
    ENC_422 = 2'd1,
    ENC_420 = 2'd2,
    ENC_RSV = 2'd3
  } enc_e;

  localparam int unsigned KEEP_6  = 6;
  localparam int unsigned KEEP_8  = 8;
  localparam int unsigned KEEP_10 = 10;

  // Kept bit count for the truncation path; "full" means pass-through.
  function automatic int unsigned trunc_keep(input logic [1:0] enc, input logic en,
                                             input logic [1:0] code, input int unsigned full);
    if (enc == ENC_422) begin
      if (code == 2'd1) return KEEP_8;
      if (code == 2'd2) return KEEP_10;
      return full;
    end
    if (!en)          return full;
    if (code == 2'd0) return KEEP_6;
    if (code == 2'd1) return KEEP_8;
    return full;
  endfunction

  // Kept bit count for the dither path; 0 means dither stays off.
  function automatic int unsigned dith_keep(input logic [1:0] code);
    case (code)
      2'd0:    return KEEP_6;
      2'd1:    return KEEP_8;
      2'd2:    return KEEP_10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pdr_frame_ctr.sv
module pdr_frame_ctr #(
  parameter int unsigned CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic [CNTW-1:0] wrap_at,
  output logic [CNTW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (step)     cnt <= (cnt >= wrap_at) ? '0 : cnt + 1'b1;
  end

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && cnt >= wrap_at) |=> (cnt == '0));
endmodule

// File: rtl/pdr_lfsr.sv
module pdr_lfsr #(
  parameter int unsigned LW  = 28,
  parameter int unsigned TAP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          hp,
  output logic [LW-1:0] noise
);
  logic [LW-1:0] s_q, prev_q, used, nxt;

  assign used  = load ? load_val : s_q;
  assign nxt   = {used[LW-2:0], used[LW-1] ^ used[TAP-1]};
  assign noise = hp ? (used - prev_q) : used;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q    <= '0;
      prev_q <= '0;
    end else if (step) begin
      s_q    <= nxt;
      prev_q <= used;
    end
  end

  // R7
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && s_q != '0) |=> (s_q != '0));
endmodule

// File: rtl/pdr_quant.sv
module pdr_quant #(
  parameter int unsigned CW = 12,
  parameter int unsigned FW = 4
) (
  input  logic [CW-1:0] val,
  input  logic [CW-1:0] nz,
  input  logic [FW-1:0] frac,
  input  logic          dith,
  input  logic          rnd,
  output logic [CW-1:0] q
);
  logic [CW-1:0] lomask, sat;
  logic [CW:0]   add, sum;

  always_comb begin
    lomask = ({{(CW-1){1'b0}}, 1'b1} << frac) - 1'b1;
    add    = '0;
    if (dith)                   add = {1'b0, nz & lomask};
    else if (rnd && frac != '0) add = {{CW{1'b0}}, 1'b1} << (frac - 1'b1);
    sum = {1'b0, val} + add;
    sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
    q   = sat & ~lomask;
  end
endmodule

// File: rtl/pix_depth_reducer.sv
module pix_depth_reducer
  import pdr_pkg::*;
#(
  parameter int unsigned CW    = 12,
  parameter int unsigned LW    = 28,
  parameter int unsigned TAP_R = 3,
  parameter int unsigned TAP_G = 9,
  parameter int unsigned TAP_B = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  output logic          in_rdy,
  input  logic          in_sof,
  input  logic [1:0]    in_enc,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  output logic          out_vld,
  input  logic          out_rdy,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b,
  input  logic          cfg_trunc_en,
  input  logic [1:0]    cfg_trunc_depth,
  input  logic          cfg_trunc_round,
  input  logic          cfg_dith_en,
  input  logic [1:0]    cfg_dith_depth,
  input  logic          cfg_rgb_rand,
  input  logic          cfg_frame_rand,
  input  logic          cfg_highpass,
  input  logic [LW-1:0] cfg_seed_r,
  input  logic [LW-1:0] cfg_seed_g,
  input  logic [LW-1:0] cfg_seed_b
);
  localparam int unsigned NCH  = 3;
  localparam int unsigned FW   = $clog2(CW + 1);
  localparam int unsigned CNTW = 4;

  logic adv, take, dith_act, armed_q, frame_ld, ld;
  int unsigned dk, tk;
  logic [FW-1:0]   frac_in;
  logic            rnd_in;
  logic [CNTW-1:0] fcnt, wrap_at;
  logic [4:0]      fr_shift;
  logic [LW-1:0]   pert;

  logic [NCH-1:0][CW-1:0] px_in, nz_sel, q;
  logic [NCH-1:0][LW-1:0] seed, nz_raw;

  logic                   p1_vld, p1_dith, p1_rnd;
  logic [FW-1:0]          p1_frac;
  logic [NCH-1:0][CW-1:0] p1_px, p1_nz, o_px;

  assign px_in = {in_b, in_g, in_r};
  assign seed  = {cfg_seed_b, cfg_seed_g, cfg_seed_r};

  assign adv    = !out_vld || out_rdy;
  assign in_rdy = adv;
  assign take   = in_vld && adv;

  always_comb begin
    dk = dith_keep(cfg_dith_depth);
    tk = trunc_keep(in_enc, cfg_trunc_en, cfg_trunc_depth, CW);
  end
  assign dith_act = cfg_dith_en && (dk != 0);
  assign frac_in  = dith_act ? FW'(CW - dk) : FW'(CW - tk);
  assign rnd_in   = !dith_act && cfg_trunc_round && (in_enc != ENC_422) && (tk < CW);

  // Frame-start reseed control
  assign wrap_at  = (cfg_dith_depth == 2'd2) ? CNTW'(3) : CNTW'(15);
  assign fr_shift = (cfg_dith_depth == 2'd2) ? 5'd8 : 5'd16;
  assign pert     = {{(LW-CNTW){1'b0}}, fcnt} << fr_shift;
  assign frame_ld = in_sof && cfg_frame_rand;
  assign ld       = take && dith_act && (frame_ld || !armed_q);

  pdr_frame_ctr #(.CNTW(CNTW)) u_fctr (
    .clk(clk), .rst_n(rst_n), .clr(!cfg_frame_rand),
    .step(take && in_sof && dith_act && cfg_frame_rand),
    .wrap_at(wrap_at), .cnt(fcnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    armed_q <= 1'b0;
    else if (take) armed_q <= dith_act;
    else           armed_q <= armed_q && dith_act;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int unsigned TAP = (i == 0) ? TAP_R : (i == 1) ? TAP_G : TAP_B;
    pdr_lfsr #(.LW(LW), .TAP(TAP)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .step(take && dith_act), .load(ld),
      .load_val(seed[i] ^ (frame_ld ? pert : '0)),
      .hp(cfg_highpass), .noise(nz_raw[i])
    );
    assign nz_sel[i] = (cfg_rgb_rand || i == 0) ? nz_raw[i][CW-1:0] : nz_raw[0][CW-1:0];

    pdr_quant #(.CW(CW), .FW(FW)) u_quant (
      .val(p1_px[i]), .nz(p1_nz[i]), .frac(p1_frac),
      .dith(p1_dith), .rnd(p1_rnd), .q(q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p1_vld  <= 1'b0;
      p1_dith <= 1'b0;
      p1_rnd  <= 1'b0;
      p1_frac <= '0;
      p1_px   <= '0;
      p1_nz   <= '0;
      out_vld <= 1'b0;
      o_px    <= '0;
    end else if (adv) begin
      p1_vld  <= in_vld;
      p1_dith <= dith_act;
      p1_rnd  <= rnd_in;
      p1_frac <= frac_in;
      p1_px   <= px_in;
      p1_nz   <= nz_sel;
      out_vld <= p1_vld;
      o_px    <= q;
    end
  end

  assign out_r = o_px[0];
  assign out_g = o_px[1];
  assign out_b = o_px[2];

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> (out_vld && $stable(out_r) && $stable(out_g) && $stable(out_b)));
  // R2
  pipe_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_vld && adv) |=> out_vld);
endmodule

// File: tb/tb_pix_depth_reducer.sv
`timescale 1ns/1ps
module tb_pix_depth_reducer;
  localparam int LW = 28;

  logic clk = 0, rst_n = 0;
  logic in_vld = 0, in_sof = 0, out_rdy = 1;
  logic [1:0] in_enc = 0;
  logic [11:0] in_r = 0, in_g = 0, in_b = 0;
  logic in_rdy, out_vld;
  logic [11:0] out_r, out_g, out_b;
  logic cfg_trunc_en = 0, cfg_trunc_round = 0, cfg_dith_en = 0;
  logic cfg_rgb_rand = 0, cfg_frame_rand = 0, cfg_highpass = 0;
  logic [1:0] cfg_trunc_depth = 0, cfg_dith_depth = 0;
  logic [LW-1:0] cfg_seed_r = 28'h1234567, cfg_seed_g = 28'hA5A5A5A, cfg_seed_b = 28'h0F0F0F1;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0, rdy_rand = 0;
  string cur_req = "R12";

  pix_depth_reducer dut (.*);

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  logic [LW-1:0] m_lf [3], m_prev [3];
  int  m_taps [3] = '{3, 9, 13};
  bit  m_armed;
  int  m_fcnt;
  bit  m1v, m2v;
  int  m1 [3], m2 [3];

  function automatic logic [LW-1:0] lstep(logic [LW-1:0] s, int t);
    return {s[LW-2:0], s[LW-1] ^ s[t-1]};
  endfunction

  function automatic int quant(int v, int keep, bit dith, bit rnd, int nz);
    int f, add, s;
    f = 12 - keep;
    if (f == 0) return v;
    add = dith ? (nz % (1 << f)) : (rnd ? (1 << (f - 1)) : 0);
    s = v + add;
    if (s > 4095) s = 4095;
    return s - (s % (1 << f));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_lf[i] = 0; m_prev[i] = 0; m1[i] = 0; m2[i] = 0; end
      m_armed = 0; m_fcnt = 0; m1v = 0; m2v = 0;
    end else begin
      bit adv, take, dact, rnd, ldd;
      int keep, chn [3], newp [3];
      logic [LW-1:0] used, pert, nzv [3];
      adv  = !m2v || out_rdy;
      take = in_vld && adv;
      dact = cfg_dith_en && cfg_dith_depth != 3;
      rnd  = 0;
      for (int i = 0; i < 3; i++) nzv[i] = 0;
      if (dact) keep = 6 + 2 * cfg_dith_depth;
      else if (in_enc == 1) keep = (cfg_trunc_depth == 1) ? 8 : (cfg_trunc_depth == 2) ? 10 : 12;
      else if (!cfg_trunc_en) keep = 12;
      else begin
        keep = (cfg_trunc_depth == 0) ? 6 : (cfg_trunc_depth == 1) ? 8 : 12;
        rnd  = cfg_trunc_round && keep < 12;
      end
      if (take && dact) begin
        ldd  = (in_sof && cfg_frame_rand) || !m_armed;
        pert = (in_sof && cfg_frame_rand) ? (LW'(m_fcnt) << ((cfg_dith_depth == 2) ? 8 : 16)) : '0;
        for (int i = 0; i < 3; i++) begin
          logic [LW-1:0] sd;
          sd = (i == 0) ? cfg_seed_r : (i == 1) ? cfg_seed_g : cfg_seed_b;
          used = ldd ? (sd ^ pert) : m_lf[i];
          nzv[i] = cfg_highpass ? used - m_prev[i] : used;
          m_prev[i] = used;
          m_lf[i] = lstep(used, m_taps[i]);
        end
      end
      chn[0] = in_r; chn[1] = in_g; chn[2] = in_b;
      for (int i = 0; i < 3; i++) begin
        int nz;
        nz = int'(cfg_rgb_rand ? nzv[i][11:0] : nzv[0][11:0]);
        newp[i] = quant(chn[i], keep, dact, rnd, nz);
      end
      if (!cfg_frame_rand) m_fcnt = 0;
      else if (take && in_sof && dact)
        m_fcnt = (m_fcnt >= ((cfg_dith_depth == 2) ? 3 : 15)) ? 0 : m_fcnt + 1;
      m_armed = take ? dact : (m_armed && dact);
      if (adv) begin
        m2v = m1v; m2 = m1;
        m1v = in_vld; m1 = newp;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(cur_req, "in_rdy", in_rdy, !m2v || out_rdy);
      chk(cur_req, "out_vld", out_vld, m2v);
      if (m2v) begin
        chk(cur_req, "out_r", out_r, m2[0]);
        chk(cur_req, "out_g", out_g, m2[1]);
        chk(cur_req, "out_b", out_b, m2[2]);
      end
    end
  end

  always @(negedge clk) out_rdy <= rdy_rand ? 1'($urandom_range(0, 1)) : 1'b1;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(int r, int g, int b, bit sof, int enc);
    @(negedge clk); #1;
    in_vld = 1; in_r = 12'(r); in_g = 12'(g); in_b = 12'(b); in_sof = sof; in_enc = 2'(enc);
    while (!in_rdy) begin @(negedge clk); #2; end
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk); #1; in_vld = 0; in_sof = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic single_expect(string req, int v, int enc, int exp);
    idle(3);
    send(v, v, v, 0, enc);
    @(negedge clk); #1; in_vld = 0; #2;
    chk(req, "latency out_vld low", out_vld, 0);
    @(negedge clk); #3;
    chk(req, "latency out_vld high", out_vld, 1);
    chk(req, "directed out_r", out_r, exp);
  endtask

  task automatic burst(int n, int enc);
    for (int k = 0; k < n; k++) send($urandom_range(0, 4095), $urandom_range(0, 4095), $urandom_range(0, 4095), 0, enc);
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3; cur_req = "R12";
    chk("R12", "reset out_vld", out_vld, 0);
    chk("R12", "reset out_r", out_r, 0);
    @(negedge clk); #1; rst_n = 1;
    #2;
    chk("R12", "post-reset out_vld", out_vld, 0);
    chk("R12", "post-reset out_b", out_b, 0);

    cur_req = "R2";  single_expect("R2", 12'hABC, 0, 12'hABC);
    cur_req = "R3";
    cfg_trunc_en = 1; cfg_trunc_depth = 0;
    single_expect("R3", 12'hABC, 0, 12'hA80);
    cfg_trunc_depth = 1; single_expect("R3", 12'hABC, 0, 12'hAB0);
    cfg_trunc_depth = 3; single_expect("R3", 12'hABC, 0, 12'hABC);
    burst(20, 0);
    cur_req = "R4";
    cfg_trunc_round = 1; cfg_trunc_depth = 1;
    single_expect("R4", 12'hABC, 0, 12'hAC0);
    cfg_trunc_depth = 0; single_expect("R4", 12'hFFF, 0, 12'hFC0);
    burst(20, 0);
    cur_req = "R5";
    cfg_trunc_en = 0; cfg_trunc_depth = 2;
    single_expect("R5", 12'hABF, 1, 12'hABC);
    cfg_trunc_depth = 1; single_expect("R5", 12'hABF, 1, 12'hAB0);
    burst(20, 1);
    cur_req = "R6";
    cfg_trunc_round = 0; cfg_dith_en = 1;
    for (int d = 0; d < 4; d++) begin cfg_dith_depth = 2'(d); burst(15, d & 1); end
    cfg_dith_depth = 0; single_expect("R6", 12'hFFF, 0, 12'hFC0);
    cur_req = "R7"; cfg_dith_depth = 2; burst(30, 0);
    cur_req = "R8"; cfg_rgb_rand = 1;
    for (int d = 0; d < 3; d++) begin cfg_dith_depth = 2'(d); burst(20, 0); end
    cur_req = "R9";
    cfg_dith_en = 0; burst(2, 0);
    cfg_dith_en = 1; burst(10, 0);
    cfg_dith_en = 0; idle(2); cfg_dith_en = 1; burst(10, 0);
    cur_req = "R10"; cfg_frame_rand = 1;
    for (int d = 0; d < 3; d += 2) begin
      cfg_dith_depth = 2'(d);
      for (int fr = 0; fr < 20; fr++) begin
        send($urandom_range(0, 4095), $urandom_range(0, 4095), $urandom_range(0, 4095), 1, 0);
        for (int k = 0; k < 3; k++) send($urandom_range(0, 4095), $urandom_range(0, 4095), $urandom_range(0, 4095), 0, 0);
      end
      idle(3);
    end
    cur_req = "R11"; cfg_highpass = 1; cfg_frame_rand = 0;
    cfg_dith_depth = 0; burst(30, 0);
    cfg_rgb_rand = 0; burst(20, 0);
    cur_req = "R1"; rdy_rand = 1; cfg_rgb_rand = 1; cfg_frame_rand = 1;
    for (int k = 0; k < 300; k++)
      send($urandom_range(0, 4095), $urandom_range(0, 4095), $urandom_range(0, 4095), (k % 7) == 0, k & 1);
    idle(2);
    rdy_rand = 0;
    idle(10);
    finish_run();
  end
endmodule